// File: doc/BRIEF.md
# Command stream method decoder

This block sits behind a word fetcher and in front of a set of register-programmed engines. Command words arrive one at a time over a valid/ready input. A header word names a method address, a subchannel, an argument count and a submission mode. The argument words that follow become register writes. The mode decides how the method address moves from one argument to the next. In inline mode the header carries its own 13-bit immediate, and no argument words follow.

Every write leaves on a valid/ready output. Each write carries the method, the subchannel, the data word, the number of arguments still to come in the same header, and the engine ID currently bound to that subchannel.

A small table holds one engine ID per subchannel. Method 0 is the bind method: it loads that table and is not forwarded. Methods 1 to 63 are reserved: they are dropped and reported on a one-cycle flag. Unknown mode codes are reported on a second flag.

An input word is taken only when the output register is empty or is being drained in the same cycle. A write therefore cannot be overwritten under backpressure.

Top module: `pb_cmd_decoder`

## Requirements
- R1: The header layout is method in bits [12:0], subchannel in [15:13], count in [28:16] and mode in [31:29]. Mode codes are: 0 and 1 increasing, 2 and 3 non-increasing, 4 inline, 5 increase-once. The two codes of each of the increasing and non-increasing pairs behave identically.
- R2: In increasing mode, argument k (counting from 0) is written to method + k.
- R3: In non-increasing mode, every argument is written to the header's method.
- R4: In increase-once mode, argument 0 goes to the header's method and every later argument goes to method + 1. A count of 0 in this mode pulses `err_mode` and emits nothing.
- R5: An inline header (mode 4) consumes no argument words. It issues one write to its method whose data is header bits [28:16], zero-extended.
- R6: Each write's `wr_remain` equals count − k − 1. An inline write carries 0.
- R7: A write to method 0 stores data bits [7:0] as the subchannel's engine ID and emits no output write. Later writes on that subchannel carry that ID on `wr_engine`. All IDs are 0 after reset.
- R8: A write to methods 1 through 63 emits no output write and pulses `err_special` for one cycle. Method 64 and above are forwarded.
- R9: Mode codes 6 and 7 pulse `err_mode` for one cycle. The header is skipped and the next word is decoded as a header.
- R10: A header with count 0 in modes 0 to 3 emits nothing. The next word is decoded as a header.
- R11: While `wr_valid` is high and `wr_ready` is low, all write outputs hold steady and `in_ready` is low.
- R12: After reset, `wr_valid`, `err_special` and `err_mode` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command word offered |
| in_ready | output | 1 | Command word accepted this cycle |
| in_data | input | 32 | Command word (header or argument) |
| wr_valid | output | 1 | Register write pending |
| wr_ready | input | 1 | Downstream takes the write |
| wr_method | output | 13 | Method address of the write |
| wr_subch | output | 3 | Subchannel of the write |
| wr_data | output | 32 | Data value of the write |
| wr_remain | output | 13 | Arguments still to follow in this header |
| wr_engine | output | 8 | Engine ID bound to the subchannel |
| err_special | output | 1 | One-cycle pulse: reserved method dropped |
| err_mode | output | 1 | One-cycle pulse: bad mode or illegal zero count |

## Verification
On every cycle, the assertions check four things:
- The held write stays frozen and input is stalled under backpressure.
- No forwarded write targets a method below 64.
- The engine field always matches the current binding of the write's subchannel.
- A reserved-method pulse is never seen alongside a fresh write.

The method sequences of each mode, the remaining counts, the inline immediate extraction, the skipping of bad or empty headers and the way a bind redirects later writes can only be shown by the bench's directed scenarios, which compare the logged writes against expected lists.

// File: rtl/pb_cmd_decoder.sv
module pb_cmd_decoder #(
  parameter int MW   = 13,
  parameter int SW   = 3,
  parameter int EW   = 8,
  parameter int NRES = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [31:0]   in_data,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [MW-1:0] wr_method,
  output logic [SW-1:0] wr_subch,
  output logic [31:0]   wr_data,
  output logic [28-MW-SW:0] wr_remain,
  output logic [EW-1:0] wr_engine,
  output logic          err_special,
  output logic          err_mode
);
  localparam int CW   = 29 - MW - SW;
  localparam int NSUB = 1 << SW;

  logic          busy;
  logic [MW-1:0] h_meth;
  logic [SW-1:0] h_sub;
  logic [CW-1:0] h_cnt, idx;
  logic [2:0]    h_mode;
  logic [EW-1:0] bind_tab [NSUB];

  wire          accept  = in_valid && in_ready;
  wire [MW-1:0] hd_meth = in_data[MW-1:0];
  wire [SW-1:0] hd_sub  = in_data[MW+SW-1:MW];
  wire [CW-1:0] hd_cnt  = in_data[28:MW+SW];
  wire [2:0]    hd_mode = in_data[31:29];

  assign in_ready = !wr_valid || wr_ready;

  logic          iss;
  logic [MW-1:0] i_meth;
  logic [SW-1:0] i_sub;
  logic [31:0]   i_data;
  logic [CW-1:0] i_rem;

  always_comb begin
    iss    = 1'b0;
    i_meth = hd_meth;
    i_sub  = hd_sub;
    i_data = 32'(hd_cnt);
    i_rem  = '0;
    if (accept) begin
      if (!busy) begin
        iss = (hd_mode == 3'd4);
      end else begin
        iss    = 1'b1;
        i_sub  = h_sub;
        i_data = in_data;
        i_rem  = h_cnt - idx - CW'(1);
        case (h_mode)
          3'd0, 3'd1: i_meth = h_meth + MW'(idx);
          3'd5:       i_meth = (idx == '0) ? h_meth : h_meth + MW'(1);
          default:    i_meth = h_meth;
        endcase
      end
    end
  end

  wire is_bind = iss && (i_meth == '0);
  wire is_res  = iss && (i_meth != '0) && (i_meth < MW'(NRES));
  wire is_wr   = iss && (i_meth >= MW'(NRES));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      idx         <= '0;
      h_meth      <= '0;
      h_sub       <= '0;
      h_cnt       <= '0;
      h_mode      <= '0;
      wr_valid    <= 1'b0;
      wr_method   <= '0;
      wr_subch    <= '0;
      wr_data     <= '0;
      wr_remain   <= '0;
      wr_engine   <= '0;
      err_special <= 1'b0;
      err_mode    <= 1'b0;
      for (int s = 0; s < NSUB; s++) bind_tab[s] <= '0;
    end else begin
      err_special <= is_res;
      err_mode    <= 1'b0;
      if (is_wr) begin
        wr_valid  <= 1'b1;
        wr_method <= i_meth;
        wr_subch  <= i_sub;
        wr_data   <= i_data;
        wr_remain <= i_rem;
        wr_engine <= bind_tab[i_sub];
      end else if (wr_ready) begin
        wr_valid <= 1'b0;
      end
      if (is_bind) bind_tab[i_sub] <= i_data[EW-1:0];
      if (accept) begin
        if (!busy) begin
          h_meth <= hd_meth;
          h_sub  <= hd_sub;
          h_cnt  <= hd_cnt;
          h_mode <= hd_mode;
          idx    <= '0;
          if (hd_mode > 3'd5 || (hd_mode == 3'd5 && hd_cnt == '0))
            err_mode <= 1'b1;
          else if (hd_mode != 3'd4 && hd_cnt != '0)
            busy <= 1'b1;
        end else begin
          idx <= idx + CW'(1);
          if (idx == h_cnt - CW'(1)) busy <= 1'b0;
        end
      end
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_method) && $stable(wr_data)
      && $stable(wr_remain) && $stable(wr_subch) && $stable(wr_engine)); // R11
  AST_STALL_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |-> !in_ready); // R11
  AST_NO_LOW_METHOD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_method >= MW'(NRES)); // R8
  AST_ENGINE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_engine == bind_tab[wr_subch]); // R7
  AST_SPECIAL_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    err_special |-> !wr_valid); // R8
endmodule

// File: tb/pb_cmd_decoder_tb.sv
`timescale 1ns/1ps
module pb_cmd_decoder_tb;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready, wr_valid, wr_ready = 1;
  logic [31:0] in_data = '0, wr_data;
  logic [12:0] wr_method, wr_remain;
  logic [2:0]  wr_subch;
  logic [7:0]  wr_engine;
  logic err_special, err_mode;

  always #2 clk = ~clk;

  pb_cmd_decoder u_dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_method(wr_method),
    .wr_subch(wr_subch), .wr_data(wr_data), .wr_remain(wr_remain), .wr_engine(wr_engine),
    .err_special(err_special), .err_mode(err_mode));

  int checks = 0, errors = 0;
  int nlog = 0, nspec = 0, nmode = 0;
  logic [12:0] lm [64];
  logic [31:0] ld [64];
  logic [12:0] lr [64];
  logic [2:0]  ls [64];
  logic [7:0]  le [64];

  always @(negedge clk) if (rst_n) begin
    if (wr_valid && wr_ready && nlog < 64) begin
      lm[nlog] = wr_method; ld[nlog] = wr_data; lr[nlog] = wr_remain;
      ls[nlog] = wr_subch;  le[nlog] = wr_engine; nlog++;
    end
    if (err_special) nspec++;
    if (err_mode) nmode++;
  end

  function automatic logic [31:0] hdr(int mode, int cnt, int sub, int meth);
    return {mode[2:0], cnt[12:0], sub[2:0], meth[12:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic send(input logic [31:0] w);
    in_valid = 1; in_data = w;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  task automatic clr(); nlog = 0; nspec = 0; nmode = 0; endtask
  task automatic drain(); repeat (4) @(posedge clk); #1; endtask

  task automatic wchk(input int i, input string tag, input int m, input int d,
                      input int r, input int s, input int e);
    chk(lm[i] == 13'(m), {tag, " method"}, lm[i], m);
    chk(ld[i] == 32'(d), {tag, " data"}, ld[i], d);
    chk(lr[i] == 13'(r), {tag, " remain"}, lr[i], r);
    chk(ls[i] == 3'(s),  {tag, " subch"}, ls[i], s);
    chk(le[i] == 8'(e),  {tag, " engine"}, le[i], e);
  endtask

  task automatic t_reset();
    chk(!wr_valid, "R12 wr_valid", wr_valid, 0);
    chk(in_ready, "R12 in_ready", in_ready, 1);
    chk(!err_special && !err_mode, "R12 flags", {err_special, err_mode}, 0);
  endtask

  task automatic t_inc();
    clr();
    send(hdr(1, 3, 2, 'h100)); send('hA0); send('hA1); send('hA2);
    send(hdr(0, 2, 6, 'h300)); send('hB0); send('hB1);
    drain();
    chk(nlog == 5, "R2 count", nlog, 5);
    wchk(0, "R2/R6 inc0", 'h100, 'hA0, 2, 2, 0);
    wchk(1, "R2/R6 inc1", 'h101, 'hA1, 1, 2, 0);
    wchk(2, "R2/R6 inc2", 'h102, 'hA2, 0, 2, 0);
    wchk(3, "R1 old inc0", 'h300, 'hB0, 1, 6, 0);
    wchk(4, "R1 old inc1", 'h301, 'hB1, 0, 6, 0);
  endtask

  task automatic t_noninc();
    clr();
    send(hdr(3, 3, 1, 'h80)); send('hC0); send('hC1); send('hC2);
    send(hdr(2, 2, 7, 'h90)); send('hD0); send('hD1);
    drain();
    chk(nlog == 5, "R3 count", nlog, 5);
    wchk(0, "R3 non0", 'h80, 'hC0, 2, 1, 0);
    wchk(1, "R3 non1", 'h80, 'hC1, 1, 1, 0);
    wchk(2, "R3 non2", 'h80, 'hC2, 0, 1, 0);
    wchk(3, "R1 old non0", 'h90, 'hD0, 1, 7, 0);
    wchk(4, "R1 old non1", 'h90, 'hD1, 0, 7, 0);
  endtask

  task automatic t_once();
    clr();
    send(hdr(5, 3, 0, 'h200)); send('hE0); send('hE1); send('hE2);
    drain();
    chk(nlog == 3, "R4 count", nlog, 3);
    wchk(0, "R4 once0", 'h200, 'hE0, 2, 0, 0);
    wchk(1, "R4 once1", 'h201, 'hE1, 1, 0, 0);
    wchk(2, "R4 once2", 'h201, 'hE2, 0, 0, 0);
    clr();
    send(hdr(5, 0, 0, 'h200)); send(hdr(4, 5, 0, 'h210));
    drain();
    chk(nmode == 1, "R4 zero count err_mode", nmode, 1);
    chk(nlog == 1 && lm[0] == 'h210, "R4 zero count skipped", nlog, 1);
  endtask

  task automatic t_inline();
    clr();
    send(hdr(4, 'h1ABC, 1, 'h150)); send(hdr(4, 'h1FFF, 2, 'h151));
    drain();
    chk(nlog == 2, "R5 count", nlog, 2);
    wchk(0, "R5/R6 inline0", 'h150, 'h1ABC, 0, 1, 0);
    wchk(1, "R5/R6 inline1", 'h151, 'h1FFF, 0, 2, 0);
  endtask

  task automatic t_bind();
    clr();
    send(hdr(4, 'h2A, 3, 0));
    drain();
    chk(nlog == 0, "R7 bind no write", nlog, 0);
    send(hdr(4, 7, 3, 'h90)); send(hdr(4, 8, 4, 'h91));
    send(hdr(1, 2, 5, 0)); send('h133); send('h55);
    send(hdr(4, 9, 5, 'h92));
    drain();
    chk(nlog == 3, "R7 write count", nlog, 3);
    wchk(0, "R7 bound subch3", 'h90, 7, 0, 3, 'h2A);
    wchk(1, "R7 unbound subch4", 'h91, 8, 0, 4, 0);
    wchk(2, "R7 bound via args", 'h92, 9, 0, 5, 'h33);
    chk(nspec == 1, "R8 method1 via inc", nspec, 1);
  endtask

  task automatic t_special();
    clr();
    send(hdr(4, 1, 0, 'h3F));
    drain();
    chk(nlog == 0 && nspec == 1, "R8 method 0x3F dropped", {nlog[7:0], nspec[7:0]}, 1);
    send(hdr(4, 2, 0, 'h40));
    drain();
    chk(nlog == 1 && lm[0] == 'h40, "R8 method 0x40 forwarded", nlog, 1);
  endtask

  task automatic t_badmode();
    clr();
    send(hdr(6, 3, 0, 'h100)); send(hdr(4, 1, 0, 'h70));
    send(hdr(7, 2, 0, 'h100)); send(hdr(4, 2, 0, 'h71));
    drain();
    chk(nmode == 2, "R9 err_mode pulses", nmode, 2);
    chk(nlog == 2 && lm[0] == 'h70 && lm[1] == 'h71, "R9 next header", nlog, 2);
  endtask

  task automatic t_zero();
    clr();
    send(hdr(1, 0, 0, 'h100)); send(hdr(3, 0, 0, 'h100)); send(hdr(4, 3, 0, 'h72));
    drain();
    chk(nlog == 1 && lm[0] == 'h72 && ld[0] == 3, "R10 zero count", nlog, 1);
    chk(nmode == 0, "R10 no err_mode", nmode, 0);
  endtask

  task automatic t_backpressure();
    clr();
    wr_ready = 0;
    fork
      begin send(hdr(1, 2, 0, 'h400)); send('hF0); send('hF1); end
    join_none
    repeat (4) @(negedge clk);
    chk(wr_valid && wr_method == 'h400 && wr_data == 'hF0, "R11 first held", wr_data, 'hF0);
    chk(!in_ready, "R11 in_ready low", in_ready, 0);
    repeat (3) @(negedge clk);
    chk(wr_valid && wr_data == 'hF0 && wr_remain == 1, "R11 still held", wr_data, 'hF0);
    @(posedge clk); #1; wr_ready = 1;
    wait fork;
    drain();
    chk(nlog == 2, "R11 nothing lost", nlog, 2);
    wchk(0, "R11 w0", 'h400, 'hF0, 1, 0, 0);
    wchk(1, "R11 w1", 'h401, 'hF1, 0, 0, 0);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    t_reset();
    rst_n = 1;
    @(posedge clk); #1;
    t_reset();
    t_inc();
    t_noninc();
    t_once();
    t_inline();
    t_bind();
    t_special();
    t_badmode();
    t_zero();
    t_backpressure();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule